// File: doc/BRIEF.md
# Serial Word Transmitter with Select Framing

This block takes a parallel word and sends it one bit at a time over a three-wire synchronous link. The link has a data line, a serial clock and an active-low select. A single-cycle start pulse launches a transfer. The block copies the word into its own register in that cycle, so the source may change the input right afterwards. Bits leave the most significant first. The serial clock is a plain registered output in the system clock domain. The receiver samples on its rising edge, and the transmitter moves the data line only when that clock falls.

The serial clock must keep an exact 50% duty cycle. For this reason, the requested bit period is rounded down to an even number of system cycles and split into two equal halves. Select drops together with the first bit, one half period before the first rising edge. It comes back up one half period after the last falling edge. The busy flag mirrors the whole framed interval. While that interval is running, start pulses have no effect. A synchronous reset ends a transfer at once.

Top module: `spi_serializer`

## Requirements
- R1: During reset and while idle, the outputs are fixed: `ser_data` 0, `ser_clk` 0, `ser_sel_n` 1 and `busy` 0.
- R2: The word sampled on the rising edges of `ser_clk` equals the word captured at the trigger, sent from bit WORD_W-1 down to bit 0, with exactly WORD_W rising edges per transfer.
- R3: Every high and every low phase of `ser_clk` lasts exactly floor(BIT_CYCLES/2) system cycles. For example, 7 gives 3 and 3.
- R4: `ser_data` changes only in the cycle where `ser_clk` falls or in the cycle where `ser_sel_n` falls.
- R5: `ser_sel_n` falls in the first cycle after the accepting clock edge, with the MSB already on `ser_data`. The first rising edge of `ser_clk` follows one half period later. `ser_sel_n` rises one half period after the last falling edge, so it stays low for (2*WORD_W+1) half periods.
- R6: `busy` is high exactly while `ser_sel_n` is low.
- R7: The word is latched when the trigger is accepted. Changes on `word_in` after that have no effect on the transfer.
- R8: A `start_in` pulse during a transfer is ignored. The running transfer keeps its word and its length, and no second transfer follows it.
- R9: Asserting `rst` in the middle of a transfer returns all outputs to the idle values of R1 after the next clock edge. A later transfer then runs normally.
- R10: A trigger in the first idle cycle after a transfer ends starts a new transfer at the next clock edge.
- R11: `ser_clk` is high only while `ser_sel_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| word_in | input | WORD_W | Parallel word to send |
| start_in | input | 1 | Trigger; accepted only when idle |
| busy | output | 1 | High for the whole framed transfer |
| ser_data | output | 1 | Serial data line, MSB first |
| ser_clk | output | 1 | Serial clock with 50% duty cycle, idles low |
| ser_sel_n | output | 1 | Active-low select, idles high |

## Verification
The bench builds the block with WORD_W = 8 and BIT_CYCLES = 7. The odd period makes the rounding visible: each half lasts 3 cycles, and a full frame is 51 cycles long. The short halves keep a whole frame within a few dozen cycles. This leaves time for all-zero, all-one and single-bit words, a trigger during a transfer, a trigger on the first idle cycle, and a reset abort.

// File: rtl/spi_ser_pkg.sv
package spi_ser_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2,
        PH_TAIL = 2'd3
    } phase_e;

    typedef struct packed {
        logic sclk;
        logic sel_n;
        logic busy;
        logic drive;
    } link_ctl_t;

    // Half of the serial bit period; odd requests round down, minimum one.
    function automatic int half_cycles(input int bit_cycles);
        return (bit_cycles / 2 < 1) ? 1 : bit_cycles / 2;
    endfunction

    function automatic link_ctl_t decode_phase(input phase_e ph);
        link_ctl_t c;
        c.sclk  = (ph == PH_HIGH);
        c.sel_n = (ph == PH_IDLE);
        c.busy  = (ph != PH_IDLE);
        c.drive = (ph == PH_LOW) || (ph == PH_HIGH);
        return c;
    endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int HALF = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic half_done
);
    localparam int CW = $clog2(HALF + 1);

    logic [CW-1:0] cnt;

    assign half_done = run && (cnt == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || half_done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] word,
    output logic         msb,
    output logic         last_bit
);
    localparam int RW = $clog2(W + 1);

    logic [W-1:0]  sh;
    logic [RW-1:0] rem;

    assign msb      = sh[W-1];
    assign last_bit = (rem == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            rem <= '0;
        end else if (load) begin
            sh  <= word;
            rem <= RW'(W - 1);
        end else if (shift) begin
            sh  <= sh << 1;
            rem <= rem - 1'b1;
        end
    end
endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_ser_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   half_done,
    input  logic   last_bit,
    output logic   load,
    output logic   shift,
    output phase_e phase
);
    assign load  = (phase == PH_IDLE) && start;
    assign shift = (phase == PH_HIGH) && half_done && !last_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE: if (start)     phase <= PH_LOW;
                PH_LOW:  if (half_done) phase <= PH_HIGH;
                PH_HIGH: if (half_done) phase <= last_bit ? PH_TAIL : PH_LOW;
                PH_TAIL: if (half_done) phase <= PH_IDLE;
                default:                phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_serializer.sv
module spi_serializer
    import spi_ser_pkg::*;
#(
    parameter int WORD_W     = 8,
    parameter int BIT_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_in,
    input  logic              start_in,
    output logic              busy,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              ser_sel_n
);
    localparam int HALF_CYC = half_cycles(BIT_CYCLES);

    phase_e    phase;
    link_ctl_t ctl;
    logic      half_done;
    logic      load;
    logic      shift;
    logic      msb;
    logic      last_bit;

    spi_half_timer #(.HALF(HALF_CYC)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (ctl.busy),
        .half_done (half_done)
    );

    spi_shifter #(.W(WORD_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .shift    (shift),
        .word     (word_in),
        .msb      (msb),
        .last_bit (last_bit)
    );

    spi_frame_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start_in),
        .half_done (half_done),
        .last_bit  (last_bit),
        .load      (load),
        .shift     (shift),
        .phase     (phase)
    );

    assign ctl       = decode_phase(phase);
    assign busy      = ctl.busy;
    assign ser_clk   = ctl.sclk;
    assign ser_sel_n = ctl.sel_n;
    assign ser_data  = ctl.drive & msb;
endmodule

// File: rtl/spi_serializer_chk.sv
module spi_serializer_chk
    import spi_ser_pkg::*;
#(
    parameter int BIT_CYCLES = 100
) (
    input logic clk,
    input logic rst,
    input logic start_in,
    input logic busy,
    input logic ser_data,
    input logic ser_clk,
    input logic ser_sel_n
);
    localparam int HALF_CYC = half_cycles(BIT_CYCLES);

    logic [31:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || !ser_clk) hi_cnt <= '0;
        else                 hi_cnt <= hi_cnt + 1'b1;
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (ser_sel_n && !ser_clk && !busy && !ser_data));

    a_r6_busy_sel: assert property (@(posedge clk) disable iff (rst)
        busy == !ser_sel_n);

    a_r11_clk_framed: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> !ser_sel_n);

    a_r4_data_edges: assert property (@(posedge clk) disable iff (rst)
        !$stable(ser_data) |-> ($fell(ser_clk) || $fell(ser_sel_n) || $past(rst)));

    a_r3_high_len: assert property (@(posedge clk) disable iff (rst)
        ($fell(ser_clk) && !$past(rst)) |-> (hi_cnt == 32'(HALF_CYC)));

    a_r5_sel_rise_clk_low: assert property (@(posedge clk) disable iff (rst)
        ($rose(ser_sel_n) && !$past(rst)) |-> (!ser_clk && !$past(ser_clk)));

    a_r8_busy_kept: assert property (@(posedge clk) disable iff (rst)
        (busy && start_in && ser_clk) |=> busy);

    a_r10_start_accept: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_in) |=> (busy && !ser_sel_n && !ser_clk));
endmodule

bind spi_serializer spi_serializer_chk #(.BIT_CYCLES(BIT_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_in  (start_in),
    .busy      (busy),
    .ser_data  (ser_data),
    .ser_clk   (ser_clk),
    .ser_sel_n (ser_sel_n)
);

// File: tb/tb_spi_serializer.sv
module tb_spi_serializer;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int BITC       = 7;
    localparam int HALF       = 3;
    localparam int FRAME      = (2 * W + 1) * HALF;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] word_in = '0;
    logic         start_in = 1'b0;
    logic         busy, ser_data, ser_clk, ser_sel_n;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_q[$];

    spi_serializer #(.WORD_W(W), .BIT_CYCLES(BITC)) dut (
        .clk(clk), .rst(rst), .word_in(word_in), .start_in(start_in),
        .busy(busy), .ser_data(ser_data), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(ser_sel_n && !ser_clk && !busy && !ser_data, req, "idle outputs",
            {busy, ser_data, ser_clk, ser_sel_n}, 4'b0001);
    endtask

    // Driver: pushes the expected word only when the trigger will be taken.
    task automatic send(input logic [W-1:0] w);
        @(negedge clk);
        word_in  = w;
        start_in = 1'b1;
        if (!busy) exp_q.push_back(w);
        @(negedge clk);
        start_in = 1'b0;
        word_in  = ~w;   // R7: input moves right after capture
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic run_word(input logic [W-1:0] w);
        int len;
        send(w);
        chk(busy && !ser_sel_n && !ser_clk && (ser_data == w[W-1]), "R5",
            "frame start", {busy, ser_sel_n, ser_clk, ser_data}, {1'b1, 1'b0, 1'b0, w[W-1]});
        len = 1;
        forever begin
            @(negedge clk);
            if (!busy) break;
            len++;
        end
        chk(len == FRAME, "R6", "busy length", len, FRAME);
    endtask

    // Monitor / scoreboard
    logic         prev_sel = 1'b1, prev_clk = 1'b0, prev_data = 1'b0;
    logic [W-1:0] got = '0;
    int           nbits = 0;
    int           run = 0;

    always @(negedge clk) begin
        if (rst) begin
            prev_sel = 1'b1; prev_clk = 1'b0; prev_data = 1'b0;
            got = '0; nbits = 0; run = 0;
        end else begin
            if (!ser_sel_n && prev_sel) begin
                run = 1;
            end else if (!ser_sel_n) begin
                if (ser_clk != prev_clk) begin
                    chk(run == HALF, "R3", "half period", run, HALF);
                    run = 1;
                end else begin
                    run++;
                end
            end
            if (ser_clk && !prev_clk) begin
                got = (got << 1) | W'(ser_data);
                nbits++;
            end
            if (ser_data != prev_data)
                chk((prev_clk && !ser_clk) || (prev_sel && !ser_sel_n), "R4",
                    "data change point", {prev_clk, ser_clk}, 2'b10);
            if (ser_clk)
                chk(!ser_sel_n, "R11", "clock outside frame", ser_sel_n, 0);
            if (ser_sel_n && !prev_sel) begin
                chk(run == HALF, "R5", "tail length", run, HALF);
                chk(nbits == W, "R2", "bit count", nbits, W);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected word", got, 0);
                end else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    chk(got == e, "R2", "word", got, e);
                end
                got = '0;
                nbits = 0;
            end
            prev_sel = ser_sel_n; prev_clk = ser_clk; prev_data = ser_data;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int len;
        logic [W-1:0] pats[6];
        pats = '{8'hA5, 8'h00, 8'hFF, 8'h01, 8'h80, 8'h3C};

        repeat (3) @(negedge clk);
        chk_idle("R1");
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1");

        // R2 R7: several patterns, input scrambled after capture
        foreach (pats[i]) run_word(pats[i]);

        // R8: trigger in the middle is ignored
        send(8'hC3);
        len = 1;
        repeat (10) begin @(negedge clk); len++; end
        start_in = 1'b1;
        word_in  = 8'hFF;
        @(negedge clk);
        len++;
        start_in = 1'b0;
        forever begin
            @(negedge clk);
            if (!busy) break;
            len++;
        end
        chk(len == FRAME, "R8", "length with stray trigger", len, FRAME);
        @(negedge clk);
        chk(!busy, "R8", "no second transfer", busy, 0);

        // R10: trigger in first idle cycle
        send(8'h96);
        do @(negedge clk); while (busy);
        start_in = 1'b1;
        word_in  = 8'h69;
        exp_q.push_back(8'h69);
        @(negedge clk);
        start_in = 1'b0;
        word_in  = 8'h00;
        chk(busy && !ser_sel_n && !ser_clk, "R10", "back-to-back start",
            {busy, ser_sel_n, ser_clk}, 3'b100);
        wait_idle();

        // R9: reset abort
        send(8'hF0);
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk_idle("R9");
        exp_q.delete();
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R9");
        run_word(8'h5A);

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule